// File: doc/BRIEF.md
# Bundle Issue and Stop-Bit Dispersal

This block sits between instruction fetch and the functional units of a statically scheduled core. It takes fixed 128-bit bundles, each with three 41-bit operation slots and a 5-bit template. The template names the unit type of every slot and marks where the compiler placed a stop. Operations that lie between stops were scheduled to be free of dependences on one another, so the block issues them together and does no hazard checking of its own.

A two-entry buffer holds the oldest and the next bundle. Each cycle the block forms one issue group. The group starts at the oldest slot that has not yet issued and may run on into the second bundle. It ends at a stop, or at the end of the buffered bundles, or just before the third operation of any one unit type. Operations are routed by type onto four typed ports, memory, integer, floating-point and branch, each with two lanes. A group goes out whole in a single cycle or waits. A bundle whose template is unused is dropped and flagged.

Top module: `bundleIssue`

## Requirements
- R1: A bundle holds its template in bits [4:0] and slot 0, 1 and 2 in bits [45:5], [86:46] and [127:87]. A slot issued on unit t, lane l appears unchanged on `opData[(2*t+l)*41 +: 41]` while `opValid[2*t+l]` is high.
- R2: Template bits [4:2] select the types of slots 0, 1 and 2: 0=MII, 1=MMI, 2=MFI, 3=MIB, 4=MBB, 5=BBB, 6=MMF, 7=MMB. The unit index t is M=0, I=1, F=2, B=3, and it also indexes `portReady`. Template bits [1:0] give the stop: 0 none, 1 after slot 2, 2 after slot 1, 3 illegal template.
- R3: A group is the run of consecutive slots in program order that starts at the oldest unissued slot. It closes after a slot that carries a stop, or at the end of the last buffered bundle. It also closes just before a slot in a bundle that is absent or illegal.
- R4: A group takes at most two operations per unit type. The slot that would be the third of its type is left for the next group. Operations of one type take lane 0 first, then lane 1, in program order.
- R5: A group dispatches, with all of its `opValid` bits high in one cycle, only when `portReady` is high for every type it uses. Otherwise no `opValid` bit is high and the block holds its state.
- R6: When the oldest buffered bundle has an illegal template, `illegalBundle` is high for one cycle and no `opValid` bit is high in that cycle. The bundle is then discarded.
- R7: `inReady` is high exactly when fewer than two bundles are buffered. A bundle accepted at a clock edge can take part in a group in the next cycle.
- R8: While reset is held, `opValid` and `illegalBundle` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Bundle offered |
| inReady | output | 1 | Buffer has room |
| inBundle | input | 128 | Offered bundle |
| portReady | input | 4 | Per-unit-type ready (M, I, F, B) |
| opValid | output | 8 | Per-lane issue strobe, index 2*type+lane |
| opData | output | 328 | Per-lane 41-bit operation |
| illegalBundle | output | 1 | Oldest bundle dropped for an unused template |

## Verification
Every output comes from the buffered state through logic only, with no register on the way. The issue strobes, the payloads and `illegalBundle` for a given buffer state and `portReady` value are therefore due in the same cycle. A bundle handed over at a rising edge first affects the outputs in the cycle that follows. The bench drives its inputs at the falling edge, waits a short delay and then compares every output with a queue-based reference model. It updates that model at the rising edge, so each expected value lines up with the cycle the design produces it.

// File: rtl/bundleIssuePkg.sv
package bundleIssuePkg;
  localparam int TMPL_W    = 5;
  localparam int SLOTS     = 3;
  localparam int DEPTH     = 2;
  localparam int WIN       = DEPTH * SLOTS;
  localparam int NUM_TYPES = 4;
  localparam int LANES     = 2;
  localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int CNT_W     = $clog2(LANES + 1);

  typedef enum logic [1:0] {
    UNIT_MEM = 2'd0,
    UNIT_INT = 2'd1,
    UNIT_FP  = 2'd2,
    UNIT_BR  = 2'd3
  } unitT;

  typedef struct packed {
    logic                   legal;
    logic [SLOTS-1:0][1:0]  kind;
    logic [SLOTS-1:0]       stopAfter;
  } tmplInfoT;

  // strobes from control to datapath
  typedef struct packed {
    logic                        push;
    logic                        wrIdx;
    logic [1:0]                  pops;
    logic [WIN-1:0]              take;
    logic [WIN-1:0][1:0]         kind;
    logic [WIN-1:0][LANE_W-1:0]  lane;
  } ctlStrobeT;

  function automatic tmplInfoT decodeTmpl(input logic [TMPL_W-1:0] t);
    tmplInfoT r;
    r.legal     = (t[1:0] != 2'd3);
    r.stopAfter = '0;
    case (t[1:0])
      2'd1:    r.stopAfter[2] = 1'b1;
      2'd2:    r.stopAfter[1] = 1'b1;
      default: r.stopAfter    = '0;
    endcase
    // kind packed as {slot2, slot1, slot0}
    case (t[4:2])
      3'd0:    r.kind = {UNIT_INT, UNIT_INT, UNIT_MEM};
      3'd1:    r.kind = {UNIT_INT, UNIT_MEM, UNIT_MEM};
      3'd2:    r.kind = {UNIT_INT, UNIT_FP,  UNIT_MEM};
      3'd3:    r.kind = {UNIT_BR,  UNIT_INT, UNIT_MEM};
      3'd4:    r.kind = {UNIT_BR,  UNIT_BR,  UNIT_MEM};
      3'd5:    r.kind = {UNIT_BR,  UNIT_BR,  UNIT_BR};
      3'd6:    r.kind = {UNIT_FP,  UNIT_MEM, UNIT_MEM};
      default: r.kind = {UNIT_BR,  UNIT_MEM, UNIT_MEM};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bundleIssueCtl.sv
module bundleIssueCtl
  import bundleIssuePkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [NUM_TYPES-1:0]          portReady,
  input  logic [DEPTH-1:0][TMPL_W-1:0]  tmpl,
  output logic                          inReady,
  output logic                          illegalBundle,
  output logic [NUM_TYPES*LANES-1:0]    opValid,
  output ctlStrobeT                     strobe
);
  logic [1:0] count, countNext;
  logic [1:0] ptr, ptrNext;

  tmplInfoT            info [DEPTH];
  logic [WIN-1:0]      slotLive;
  logic [WIN-1:0]      slotStop;
  logic [WIN-1:0][1:0] slotKind;

  always_comb begin
    for (int b = 0; b < DEPTH; b++) info[b] = decodeTmpl(tmpl[b]);
    for (int q = 0; q < WIN; q++) begin
      slotLive[q] = (int'(count) > q / SLOTS) && info[q / SLOTS].legal;
      slotStop[q] = info[q / SLOTS].stopAfter[q % SLOTS];
      slotKind[q] = info[q / SLOTS].kind[q % SLOTS];
    end
  end

  // group formation: walk the window from the pointer
  logic                         openG;
  logic [WIN-1:0]               takeV;
  logic [WIN-1:0][LANE_W-1:0]   laneV;
  logic [CNT_W-1:0]             useCnt [NUM_TYPES];
  logic [2:0]                   taken;

  always_comb begin
    openG = 1'b1;
    takeV = '0;
    laneV = '0;
    taken = '0;
    for (int t = 0; t < NUM_TYPES; t++) useCnt[t] = '0;
    for (int q = 0; q < WIN; q++) begin
      if (openG && q >= int'(ptr)) begin
        if (!slotLive[q]) begin
          openG = 1'b0;
        end else if (useCnt[slotKind[q]] == CNT_W'(LANES)) begin
          openG = 1'b0;
        end else begin
          takeV[q]               = 1'b1;
          laneV[q]               = useCnt[slotKind[q]][LANE_W-1:0];
          useCnt[slotKind[q]]    = useCnt[slotKind[q]] + 1'b1;
          taken                  = taken + 3'd1;
          if (slotStop[q]) openG = 1'b0;
        end
      end
    end
  end

  logic                 headIllegal, groupFire, allReady;
  logic [NUM_TYPES-1:0] usedType;
  logic [2:0]           endPos;
  logic [1:0]           popsG, pops;

  always_comb begin
    for (int t = 0; t < NUM_TYPES; t++) usedType[t] = (useCnt[t] != '0);
    allReady    = &(portReady | ~usedType);
    headIllegal = (count != 2'd0) && !info[0].legal;
    groupFire   = (count != 2'd0) && !headIllegal && allReady;
    endPos      = 3'(ptr) + taken;
    popsG       = (endPos >= 3'd6) ? 2'd2 : (endPos >= 3'd3) ? 2'd1 : 2'd0;
    pops        = groupFire ? popsG : (headIllegal ? 2'd1 : 2'd0);
    ptrNext     = groupFire ? 2'(endPos - 3'(popsG) * 3'd3)
                            : (headIllegal ? 2'd0 : ptr);
    inReady     = (count < 2'd2);
    countNext   = count - pops + {1'b0, inValid && inReady};
    for (int t = 0; t < NUM_TYPES; t++)
      for (int l = 0; l < LANES; l++)
        opValid[t*LANES+l] = groupFire && (int'(useCnt[t]) > l);
  end

  assign illegalBundle = headIllegal;

  always_comb begin
    strobe.push  = inValid && inReady;
    strobe.pops  = pops;
    strobe.wrIdx = 1'(count - pops);
    strobe.take  = takeV;
    strobe.kind  = slotKind;
    strobe.lane  = laneV;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
      ptr   <= '0;
    end else begin
      count <= countNext;
      ptr   <= ptrNext;
    end
  end

  // R5 / R4: whole-group dispatch and lane order, per unit type
  for (genvar t = 0; t < NUM_TYPES; t++) begin : gChk
    a_r5_ready_gate: assert property (@(posedge clk) disable iff (!rstN)
      (|opValid[t*LANES +: LANES]) |-> portReady[t]);
    a_r4_lane_order: assert property (@(posedge clk) disable iff (!rstN)
      opValid[t*LANES+1] |-> opValid[t*LANES]);
  end

  a_r6_illegal_quiet: assert property (@(posedge clk) disable iff (!rstN)
    illegalBundle |-> (opValid == '0));

  a_r3_ptr_range: assert property (@(posedge clk) disable iff (!rstN)
    ptr < 2'd3);

  a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (count != 2'd0));

  a_r7_no_overfill: assert property (@(posedge clk) disable iff (!rstN)
    count <= 2'd2);
endmodule

// File: rtl/bundleIssueDp.sv
module bundleIssueDp
  import bundleIssuePkg::*;
#(
  parameter int SLOT_W   = 41,
  parameter int BUNDLE_W = TMPL_W + SLOTS * SLOT_W
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic [BUNDLE_W-1:0]                    inBundle,
  input  ctlStrobeT                              strobe,
  output logic [DEPTH-1:0][TMPL_W-1:0]           tmpl,
  output logic [NUM_TYPES*LANES-1:0][SLOT_W-1:0] opData
);
  logic [BUNDLE_W-1:0] bundleMem [DEPTH];
  logic [BUNDLE_W-1:0] memNext   [DEPTH];
  logic [WIN-1:0][SLOT_W-1:0] slotData;

  for (genvar b = 0; b < DEPTH; b++) begin : gTmpl
    assign tmpl[b] = bundleMem[b][TMPL_W-1:0];
  end

  for (genvar q = 0; q < WIN; q++) begin : gSlot
    assign slotData[q] = bundleMem[q / SLOTS][TMPL_W + (q % SLOTS) * SLOT_W +: SLOT_W];
  end

  always_comb begin
    memNext[0] = (strobe.pops == 2'd1) ? bundleMem[1] : bundleMem[0];
    memNext[1] = bundleMem[1];
    if (strobe.push) begin
      if (strobe.wrIdx) memNext[1] = inBundle;
      else              memNext[0] = inBundle;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int b = 0; b < DEPTH; b++) bundleMem[b] <= '0;
    end else begin
      for (int b = 0; b < DEPTH; b++) bundleMem[b] <= memNext[b];
    end
  end

  // route taken slots to the typed lanes
  always_comb begin
    opData = '0;
    for (int q = 0; q < WIN; q++)
      if (strobe.take[q])
        opData[int'(strobe.kind[q]) * LANES + int'(strobe.lane[q])] = slotData[q];
  end
endmodule

// File: rtl/bundleIssue.sv
module bundleIssue
  import bundleIssuePkg::*;
#(
  parameter int SLOT_W   = 41,
  parameter int BUNDLE_W = TMPL_W + SLOTS * SLOT_W,
  parameter int LANE_CNT = NUM_TYPES * LANES
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [BUNDLE_W-1:0]          inBundle,
  input  logic [NUM_TYPES-1:0]         portReady,
  output logic [LANE_CNT-1:0]          opValid,
  output logic [LANE_CNT*SLOT_W-1:0]   opData,
  output logic                         illegalBundle
);
  ctlStrobeT                           strobe;
  logic [DEPTH-1:0][TMPL_W-1:0]        tmpl;
  logic [LANE_CNT-1:0][SLOT_W-1:0]     laneData;

  bundleIssueCtl uCtl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .portReady(portReady),
    .tmpl(tmpl), .inReady(inReady), .illegalBundle(illegalBundle),
    .opValid(opValid), .strobe(strobe)
  );

  bundleIssueDp #(.SLOT_W(SLOT_W), .BUNDLE_W(BUNDLE_W)) uDp (
    .clk(clk), .rstN(rstN), .inBundle(inBundle), .strobe(strobe),
    .tmpl(tmpl), .opData(laneData)
  );

  assign opData = laneData;
endmodule

// File: tb/tb_bundleIssue.sv
`timescale 1ns/1ps
module tb_bundleIssue;
  localparam int SW = 41;

  logic         clk = 1'b0;
  logic         rstN;
  logic         inValid;
  logic         inReady;
  logic [127:0] inBundle;
  logic [3:0]   portReady;
  logic [7:0]   opValid;
  logic [8*SW-1:0] opData;
  logic         illegalBundle;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  bundleIssue dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inBundle(inBundle), .portReady(portReady), .opValid(opValid),
    .opData(opData), .illegalBundle(illegalBundle)
  );

  // reference state
  logic [127:0] q[$];
  int ptr;

  // R2: slot types per pattern, M=0 I=1 F=2 B=3
  function automatic int kindOf(logic [127:0] b, int s);
    int k[3];
    case (b[4:2])
      3'd0: k = '{0, 1, 1};
      3'd1: k = '{0, 0, 1};
      3'd2: k = '{0, 2, 1};
      3'd3: k = '{0, 1, 3};
      3'd4: k = '{0, 3, 3};
      3'd5: k = '{3, 3, 3};
      3'd6: k = '{0, 0, 2};
      default: k = '{0, 0, 3};
    endcase
    return k[s];
  endfunction

  function automatic bit stopAt(logic [127:0] b, int s);
    return (b[1:0] == 2'd1 && s == 2) || (b[1:0] == 2'd2 && s == 1);
  endfunction

  function automatic bit isLegal(logic [127:0] b);
    return b[1:0] != 2'd3;
  endfunction

  // R1: slot field positions
  function automatic logic [SW-1:0] slotOf(logic [127:0] b, int s);
    return b[5 + s*SW +: SW];
  endfunction

  function automatic logic [127:0] makeBundle(int mode);
    logic [127:0] b;
    logic [1:0] sc;
    b = {$urandom, $urandom, $urandom, $urandom};
    case (mode)
      0: sc = 2'($urandom % 3);
      1: sc = 2'd0;
      2: sc = ($urandom % 4 == 0) ? 2'd3 : 2'($urandom % 3);
      default: sc = 2'd1;
    endcase
    b[4:0] = {3'($urandom % 8), sc};
    return b;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // expected outputs for the current state and inputs
  logic [7:0]    eValid;
  logic [SW-1:0] eData [8];
  bit            eIll, eReady;
  int            ePops, ePtr;

  task automatic predict();
    int cnt[4];
    int i, endI, b, s, ty;
    bit stopNow, ok;
    eValid = '0; eIll = 0; ePops = 0; ePtr = ptr;
    eReady = (q.size() < 2);
    for (int l = 0; l < 8; l++) eData[l] = '0;
    if (q.size() == 0) return;
    if (!isLegal(q[0])) begin
      eIll = 1; ePops = 1; ePtr = 0;
      return;
    end
    cnt = '{0, 0, 0, 0};
    i = ptr; endI = ptr; stopNow = 0;
    while (!stopNow && i < 6) begin
      b = i / 3; s = i % 3;
      if (b >= q.size() || !isLegal(q[b])) break;
      ty = kindOf(q[b], s);
      if (cnt[ty] == 2) break;
      eValid[ty*2 + cnt[ty]] = 1'b1;
      eData[ty*2 + cnt[ty]]  = slotOf(q[b], s);
      cnt[ty]++;
      endI = i + 1;
      stopNow = stopAt(q[b], s);
      i++;
    end
    ok = 1;
    for (int t = 0; t < 4; t++) if (cnt[t] > 0 && !portReady[t]) ok = 0;
    if (ok) begin
      ePops = endI / 3;
      ePtr  = endI % 3;
    end else begin
      eValid = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; inValid = 1'b0; inBundle = '0; portReady = 4'hF;
    ptr = 0;
    repeat (3) @(negedge clk);
    #1;
    check(opValid == '0, "R8 opValid in reset", 64'(opValid), 64'd0);
    check(illegalBundle == 1'b0, "R8 illegalBundle in reset", 64'(illegalBundle), 64'd0);
    check(inReady == 1'b1, "R8 inReady in reset", 64'(inReady), 64'd1);
    @(negedge clk);
    rstN = 1'b1;

    for (int phase = 0; phase < 4; phase++) begin
      for (int c = 0; c < 700; c++) begin
        @(negedge clk);
        inValid  = ($urandom % 4) != 0;
        inBundle = makeBundle(phase);
        if (phase == 0 || phase == 2) portReady = 4'hF;
        else for (int t = 0; t < 4; t++) portReady[t] = ($urandom % 4) != 0;
        #1;
        predict();
        check(inReady == eReady, "R7 inReady", 64'(inReady), 64'(eReady));
        check(illegalBundle == eIll, "R6 illegalBundle", 64'(illegalBundle), 64'(eIll));
        if (portReady != 4'hF)
          check(opValid == eValid, "R5 group gated by readies", 64'(opValid), 64'(eValid));
        else
          check(opValid == eValid, "R3 R2 group extent", 64'(opValid), 64'(eValid));
        for (int l = 0; l < 8; l++)
          if (eValid[l])
            check(opData[l*SW +: SW] == eData[l], "R1 R4 lane payload",
                  64'(opData[l*SW +: SW]), 64'(eData[l]));
        @(posedge clk);
        for (int p = 0; p < ePops; p++) void'(q.pop_front());
        ptr = ePtr;
        if (inValid && eReady) q.push_back(inBundle);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule